// File: doc/BRIEF.md
# Peripheral Output Pin Steering

This block chooses, for each of eight steerable peripheral outputs, which of two candidate pins carries that output. The outputs belong to three compare/PWM channels that each have several outputs. A select register holds one bit per function and is loaded through a small write-only register port. A bit of 0 picks the function's primary pin and a bit of 1 picks its alternate pin. While a function's enable is high, its data drives the selected pin and that pin is forced to output. The other candidate pin, and every pin outside the mapping, passes its GPIO latch and output-enable straight through.

The block holds no direction storage. The GPIO latch and output-enable values are inputs and are never written back, so moving a function between pins cannot disturb any direction setting. In the default mapping, function f has primary pin f and alternate pin 8+f. Pins 16 to 19 belong to no function.

Top module: `pin_func_steer`

## Requirements
- R1: After reset the select register is all zeros, so every enabled function drives its primary pin (pin f for function f).
- R2: A write with `wr_en` high and `wr_addr` equal to 5 loads `wr_data` into the select register at that clock edge. Pin routing changes only after that edge.
- R3: While function f is enabled and its select bit is 0, pin f outputs `periph_dat[f]` with its output-enable high.
- R4: While function f is enabled and its select bit is 1, pin 8+f outputs `periph_dat[f]` with its output-enable high.
- R5: While function f is enabled, the candidate pin that is not selected outputs its own `gpio_lat` and `gpio_oe` bits.
- R6: While function f is disabled, both of its candidate pins output their own `gpio_lat` and `gpio_oe` bits, whatever its select bit is.
- R7: Pins 16 to 19 always output their own `gpio_lat` and `gpio_oe` bits.
- R8: A pin that carries an active override has output-enable 1 even when its `gpio_oe` bit is 0.
- R9: A write to any address other than 5 leaves the select register and the pin routing unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data, one select bit per function |
| gpio_lat | input | 20 | Per-pin GPIO output latch value |
| gpio_oe | input | 20 | Per-pin GPIO output enable (1 = drive) |
| periph_en | input | 8 | Per-function peripheral output enable |
| periph_dat | input | 8 | Per-function peripheral output data |
| pin_dout | output | 20 | Final per-pin output data |
| pin_oe | output | 20 | Final per-pin output enable |

## Verification
Pin outputs depend combinationally on the GPIO, enable and data inputs. The bench therefore drives those inputs just after a falling edge and checks the pins a nanosecond later, in the same cycle. A select write only takes effect at the rising edge that samples it. The bench checks the old routing while the write is still pending and the new routing after the following falling edge. Its model of the select register is updated only at that point. Random enables, data and GPIO values are mixed with random writes to the select address and to other addresses. The directed cases cover the reset state and overrides on pins whose `gpio_oe` is 0.

// File: rtl/pin_func_steer.sv
module pin_func_steer #(
  parameter int NUM_FUNC = 8,
  parameter int NUM_PIN  = 20,
  parameter int ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 4'd5,
  localparam int PIN_W = $clog2(NUM_PIN),
  parameter logic [NUM_FUNC*PIN_W-1:0] PRI_MAP =
    {5'd7, 5'd6, 5'd5, 5'd4, 5'd3, 5'd2, 5'd1, 5'd0},
  parameter logic [NUM_FUNC*PIN_W-1:0] ALT_MAP =
    {5'd15, 5'd14, 5'd13, 5'd12, 5'd11, 5'd10, 5'd9, 5'd8}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [NUM_FUNC-1:0] wr_data,
  input  logic [NUM_PIN-1:0]  gpio_lat,
  input  logic [NUM_PIN-1:0]  gpio_oe,
  input  logic [NUM_FUNC-1:0] periph_en,
  input  logic [NUM_FUNC-1:0] periph_dat,
  output logic [NUM_PIN-1:0]  pin_dout,
  output logic [NUM_PIN-1:0]  pin_oe
);

  logic [NUM_FUNC-1:0] sel_q;
  logic                sel_wr;

  assign sel_wr = wr_en && (wr_addr == SEL_ADDR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      sel_q <= '0;
    else if (sel_wr) sel_q <= wr_data;

  function automatic logic [PIN_W-1:0] target(input int f, input logic alt);
    return alt ? ALT_MAP[f*PIN_W +: PIN_W] : PRI_MAP[f*PIN_W +: PIN_W];
  endfunction

  // Lower function index wins if a custom map ever shares a pin.
  always_comb begin
    pin_dout = gpio_lat;
    pin_oe   = gpio_oe;
    for (int f = NUM_FUNC - 1; f >= 0; f--) begin
      if (periph_en[f]) begin
        pin_dout[target(f, sel_q[f])] = periph_dat[f];
        pin_oe[target(f, sel_q[f])]   = 1'b1;
      end
    end
  end

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> sel_q == '0);

  p_sel_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> sel_q == $past(wr_data));

  p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> $stable(sel_q));

  // The checks below assume the candidate pins of different functions do not overlap.
  for (genvar g = 0; g < NUM_FUNC; g++) begin : g_chk
    localparam int PP = int'(PRI_MAP[g*PIN_W +: PIN_W]);
    localparam int AP = int'(ALT_MAP[g*PIN_W +: PIN_W]);

    p_pri_ovr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      periph_en[g] && !sel_q[g] |-> pin_oe[PP] && pin_dout[PP] == periph_dat[g]);

    p_alt_ovr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      periph_en[g] && sel_q[g] |-> pin_oe[AP] && pin_dout[AP] == periph_dat[g]);

    p_unsel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      periph_en[g] |->
        (sel_q[g] ? (pin_dout[PP] == gpio_lat[PP] && pin_oe[PP] == gpio_oe[PP])
                  : (pin_dout[AP] == gpio_lat[AP] && pin_oe[AP] == gpio_oe[AP])));

    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !periph_en[g] |-> pin_dout[PP] == gpio_lat[PP] && pin_oe[PP] == gpio_oe[PP] &&
                        pin_dout[AP] == gpio_lat[AP] && pin_oe[AP] == gpio_oe[AP]);
  end

endmodule

// File: tb/test_pin_func_steer.sv
module test_pin_func_steer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [19:0] gpio_lat = '0, gpio_oe = '0;
  logic [7:0]  periph_en = '0, periph_dat = '0;
  logic [19:0] pin_dout, pin_oe;

  logic [7:0]  sel_m = '0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pin_func_steer i_pin_func_steer (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .gpio_lat, .gpio_oe,
    .periph_en, .periph_dat, .pin_dout, .pin_oe
  );

  function automatic logic [1:0] exp_pin(input int p);
    int f;
    if (p >= 16) return {gpio_oe[p], gpio_lat[p]};
    f = p % 8;
    if (periph_en[f] && (sel_m[f] == (p >= 8))) return {1'b1, periph_dat[f]};
    return {gpio_oe[p], gpio_lat[p]};
  endfunction

  function automatic string tag_pin(input int p);
    int f;
    if (p >= 16) return "R7";
    f = p % 8;
    if (!periph_en[f]) return "R6";
    if (sel_m[f] != (p >= 8)) return "R5";
    if (!gpio_oe[p]) return "R8";
    return (p < 8) ? "R3" : "R4";
  endfunction

  task automatic check_pins(input string ctx);
    for (int p = 0; p < 20; p++) begin
      logic [1:0] e;
      e = exp_pin(p);
      checks++;
      if ({pin_oe[p], pin_dout[p]} !== e) begin
        errors++;
        $display("FAIL %s %s pin %0d: got oe/dout=%b expected %b",
                 tag_pin(p), ctx, p, {pin_oe[p], pin_dout[p]}, e);
      end
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [7:0] d, input string ctx);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    #1 check_pins({ctx, " pending"});
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 4'd5) sel_m = d;
    #1 check_pins(ctx);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset selects primary pins; overrides with gpio_oe low also cover R8
    @(negedge clk);
    periph_en = 8'hFF; periph_dat = 8'hA5; gpio_lat = 20'hFFFFF; gpio_oe = '0;
    #1 check_pins("R1 reset select");
    // R2 directed: move all to alternate pins
    reg_write(4'd5, 8'hFF, "R2 write all alt");
    // R9: wrong address leaves routing alone
    reg_write(4'd4, 8'h00, "R9 wrong addr");
    reg_write(4'd6, 8'h0F, "R9 wrong addr");
    // R6: disabled functions behave as GPIO regardless of selection
    @(negedge clk);
    periph_en = 8'h00; gpio_lat = 20'h5A5A5; gpio_oe = 20'hF0F0F;
    #1 check_pins("R6 all disabled");
    reg_write(4'd5, 8'h3C, "R2 mixed select");
    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(0, 7) == 0) begin
        logic [3:0] a;
        a = ($urandom_range(0, 1) == 0) ? 4'd5 : 4'($urandom_range(0, 15));
        reg_write(a, 8'($urandom), "R2/R9 random write");
      end else begin
        @(negedge clk);
        gpio_lat   = 20'($urandom);
        gpio_oe    = 20'($urandom);
        periph_en  = 8'($urandom);
        periph_dat = 8'($urandom);
        #1 check_pins("random");
      end
    end
    // Reset again mid-run: R1
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; sel_m = '0; periph_en = 8'hFF; gpio_oe = '0;
    #1 check_pins("R1 re-reset");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule